// File: doc/BRIEF.md
# Counter-Based Register File

This block holds the architectural registers of a small processor. There are sixteen register numbers. Eleven of them are stored locally: the program counter, five general registers and five address registers. Each stored register is a loadable up/down counter, so an instruction can change a register by one, before or after using it, without going through the ALU. The other five numbers are data windows. They hold no storage. Reading one returns the read-data input of its memory port, and writing one raises that port's write strobe.

Every stored register has its own synchronous clear, its own increment request and its own decrement request. The program counter is the exception for updates: it advances by one on each instruction step, and increment or decrement requests aimed at it are ignored. There is one write port and a parameterised number of read ports (two by default). The read ports are combinational and use two levels of muxing: first a four-member bank is chosen, then a member within that bank.

Register numbers: PC=0, R1=1, R2..R5=2..5, A1=6, D1=7, A2=8, D2=9, A3=10, D3=11, A4=12, D4=13, A5=14, D5=15.

Top module: `ctr_regfile`

## Requirements
- R1: A synchronous active-low reset sets all eleven stored registers to 0x0000.
- R2: A write with `wr_en`=1 to a stored register number appears on every read port from the next cycle on.
- R3: An increment request on a stored non-PC register adds one and a decrement request subtracts one, both modulo 2^16 (0x0000 minus one gives 0xFFFF, 0xFFFF plus one gives 0x0000).
- R4: Increment and decrement requests on the same register in the same cycle cancel, and the register keeps its value.
- R5: A write to a register takes priority over an increment or decrement of that register in the same cycle, and the update is dropped.
- R6: A clear request sets its register to zero ahead of a write, an update or a PC step in the same cycle. It touches no other register.
- R7: With `step_en`=1 the PC (number 0) increases by one per cycle. Increment and decrement requests on bit 0 are ignored. A write to number 0 takes priority over the step.
- R8: Reading D1, D2, D3, D4 or D5 (numbers 7, 9, 11, 13, 15) returns the slice of `mem_rdata` for memory port 0, 1, 2, 3 or 4 respectively. Port k occupies bits [16k+15:16k].
- R9: A write to a data-window number k drives `mem_wr_stb` with only bit k set in that same cycle, and `mem_wdata` equals `wr_data`. No stored register changes. Update and clear requests on window numbers have no effect. The strobe stays all zero when the write targets a stored register or when `wr_en`=0.
- R10: Each read port returns register n for every number n, and the ports are independent. Internally the banks are {PC,R1,A1,D1}, {R2..R5}, {A2,D2,A3,D3} and {A4,D4,A5,D5}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | Advance the PC by one |
| wr_en | input | 1 | Write-port enable |
| wr_sel | input | 4 | Write register number |
| wr_data | input | 16 | Write data |
| inc_req | input | 16 | Per-register increment requests, bit n = register n |
| dec_req | input | 16 | Per-register decrement requests, bit n = register n |
| clr_req | input | 16 | Per-register clear requests, bit n = register n |
| mem_rdata | input | 80 | Read data of the five memory ports, port k at [16k+15:16k] |
| mem_wr_stb | output | 5 | Write strobe for each memory port |
| mem_wdata | output | 16 | Write data forwarded to the memory ports |
| rd_sel | input | 8 | Read register numbers, port p at [4p+3:4p] |
| rd_data | output | 32 | Read data, port p at [16p+15:16p] |

## Verification
A wrong counter next-state, such as a bad priority, a wrong wrap or a missing cancel, shows up as a wrong value on a read port one cycle after the stimulus. Reading the register back on the next cycle therefore locates the fault to a single operation. A wrong routing entry in the read mux is visible in the same cycle, but only for the register number that is mis-routed. For that reason every number is read on both ports, and the ports use different orders. A window that is decoded as storage, or a counter that is decoded as a window, shows up either as a stray strobe in the same cycle or as a read-back of the memory input where stored data was expected.

// File: rtl/ctr_regfile_pkg.sv
package ctr_regfile_pkg;

   localparam int NUM_REGS = 16;
   localparam int SEL_W    = 4;
   localparam int NUM_MEM  = 5;
   localparam int GROUPS   = 4;
   localparam int MEMBERS  = 4;

   typedef struct packed {
      logic [1:0] grp;
      logic [1:0] mbr;
   } rd_route_t;

   // numbers 7, 9, 11, 13, 15 are memory windows
   function automatic bit is_window(int n);
      return (n == 7) || (n >= 9 && (n % 2) == 1);
   endfunction

   function automatic int window_port(int n);
      return (n - 7) / 2;
   endfunction

   // register number held by member m of bank g
   function automatic int member_reg(int g, int m);
      if (g == 0) return (m < 2) ? m : m + 4;
      if (g == 1) return m + 2;
      return g * MEMBERS + m;
   endfunction

   // inverse of member_reg
   function automatic rd_route_t route(logic [SEL_W-1:0] n);
      rd_route_t r;
      if (n[3]) begin
         r.grp = n[3:2];
         r.mbr = n[1:0];
      end else if (n >= 4'd2 && n <= 4'd5) begin
         r.grp = 2'd1;
         r.mbr = 2'(n - 4'd2);
      end else begin
         r.grp = 2'd0;
         r.mbr = {n[2], n[0]};
      end
      return r;
   endfunction

endpackage

// File: rtl/updown_cell.sv
module updown_cell #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         up,
   input  logic         dn,
   output logic [W-1:0] q
);

   logic [W-1:0] q_nxt;

   always_comb begin
      if (clr)             q_nxt = '0;
      else if (ld)         q_nxt = ld_val;
      else if (up && !dn)  q_nxt = q + 1'b1;
      else if (dn && !up)  q_nxt = q - 1'b1;
      else                 q_nxt = q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= q_nxt;
   end

endmodule

// File: rtl/group_mux.sv
module group_mux
   import ctr_regfile_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [NUM_REGS*W-1:0] words,
   input  logic [SEL_W-1:0]      sel,
   output logic [W-1:0]          dout
);

   logic [W-1:0] member [GROUPS][MEMBERS];
   logic [W-1:0] bank_out [GROUPS];
   rd_route_t    rt;

   assign rt = route(sel);

   for (genvar g = 0; g < GROUPS; g++) begin : g_bank
      for (genvar m = 0; m < MEMBERS; m++) begin : g_mbr
         assign member[g][m] = words[member_reg(g, m)*W +: W];
      end
      assign bank_out[g] = member[g][rt.mbr];
   end

   assign dout = bank_out[rt.grp];

endmodule

// File: rtl/ctr_regfile.sv
module ctr_regfile
   import ctr_regfile_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int RD_PORTS = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       step_en,
   input  logic                       wr_en,
   input  logic [SEL_W-1:0]           wr_sel,
   input  logic [DATA_W-1:0]          wr_data,
   input  logic [NUM_REGS-1:0]        inc_req,
   input  logic [NUM_REGS-1:0]        dec_req,
   input  logic [NUM_REGS-1:0]        clr_req,
   input  logic [NUM_MEM*DATA_W-1:0]  mem_rdata,
   output logic [NUM_MEM-1:0]         mem_wr_stb,
   output logic [DATA_W-1:0]          mem_wdata,
   input  logic [RD_PORTS*SEL_W-1:0]  rd_sel,
   output logic [RD_PORTS*DATA_W-1:0] rd_data
);

   if (DATA_W < 2)   begin : g_bad_w   $error("DATA_W must be at least 2");  end
   if (RD_PORTS < 1) begin : g_bad_rd  $error("RD_PORTS must be at least 1"); end

   logic [NUM_REGS*DATA_W-1:0] word_flat;
   logic                       unused_bits;

   // request bits on windows and PC updates are dropped on purpose
   assign unused_bits = ^{inc_req, dec_req, clr_req};

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      if (is_window(i)) begin : g_win
         assign word_flat[i*DATA_W +: DATA_W] =
            mem_rdata[window_port(i)*DATA_W +: DATA_W];
      end else begin : g_ctr
         logic up_i, dn_i;
         if (i == 0) begin : g_pc
            assign up_i = step_en;
            assign dn_i = 1'b0;
         end else begin : g_gen
            assign up_i = inc_req[i];
            assign dn_i = dec_req[i];
         end
         updown_cell #(.W(DATA_W)) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (clr_req[i]),
            .ld     (wr_en && (wr_sel == SEL_W'(i))),
            .ld_val (wr_data),
            .up     (up_i),
            .dn     (dn_i),
            .q      (word_flat[i*DATA_W +: DATA_W])
         );
      end
   end

   for (genvar k = 0; k < NUM_MEM; k++) begin : g_stb
      assign mem_wr_stb[k] = wr_en && (wr_sel == SEL_W'(7 + 2*k));
   end
   assign mem_wdata = wr_data;

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      group_mux #(.W(DATA_W)) u_mux (
         .words (word_flat),
         .sel   (rd_sel[p*SEL_W +: SEL_W]),
         .dout  (rd_data[p*DATA_W +: DATA_W])
      );
   end

endmodule

// File: rtl/ctr_regfile_chk.sv
module ctr_regfile_chk
   import ctr_regfile_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int RD_PORTS = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       step_en,
   input logic                       wr_en,
   input logic [SEL_W-1:0]           wr_sel,
   input logic [DATA_W-1:0]          wr_data,
   input logic [NUM_REGS-1:0]        inc_req,
   input logic [NUM_REGS-1:0]        dec_req,
   input logic [NUM_REGS-1:0]        clr_req,
   input logic [NUM_MEM-1:0]         mem_wr_stb,
   input logic [RD_PORTS*SEL_W-1:0]  rd_sel,
   input logic [RD_PORTS*DATA_W-1:0] rd_data,
   input logic [NUM_REGS*DATA_W-1:0] word_flat
);

   logic [DATA_W-1:0] w [NUM_REGS];
   for (genvar i = 0; i < NUM_REGS; i++) begin : g_w
      assign w[i] = word_flat[i*DATA_W +: DATA_W];
   end

   a_r9_stb_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mem_wr_stb));

   a_r9_stb_needs_wr: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> mem_wr_stb == '0);

   a_r7_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !clr_req[0] && !(wr_en && wr_sel == '0))
      |=> w[0] == $past(w[0]) + 1'b1);

   a_r5_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !is_window(int'(wr_sel)) && !clr_req[wr_sel])
      |=> w[$past(wr_sel)] == $past(wr_data));

   a_r3_r1_up: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_req[1] && !dec_req[1] && !clr_req[1] && !(wr_en && wr_sel == 4'd1))
      |=> w[1] == $past(w[1]) + 1'b1);

   a_r4_r1_cancel: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_req[1] && dec_req[1] && !clr_req[1] && !(wr_en && wr_sel == 4'd1))
      |=> $stable(w[1]));

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_clr
      if (!is_window(i)) begin : g_c
         a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
            clr_req[i] |=> w[i] == '0);
      end
   end

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rdchk
      a_r10_read_route: assert property (@(posedge clk) disable iff (!rst_n)
         rd_data[p*DATA_W +: DATA_W] == w[rd_sel[p*SEL_W +: SEL_W]]);
   end

endmodule

bind ctr_regfile ctr_regfile_chk #(.DATA_W(DATA_W), .RD_PORTS(RD_PORTS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .step_en    (step_en),
   .wr_en      (wr_en),
   .wr_sel     (wr_sel),
   .wr_data    (wr_data),
   .inc_req    (inc_req),
   .dec_req    (dec_req),
   .clr_req    (clr_req),
   .mem_wr_stb (mem_wr_stb),
   .rd_sel     (rd_sel),
   .rd_data    (rd_data),
   .word_flat  (word_flat)
);

// File: tb/ctr_regfile_test.sv
`timescale 1ns/1ps
module ctr_regfile_test;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        step_en, wr_en;
   logic [3:0]  wr_sel;
   logic [15:0] wr_data;
   logic [15:0] inc_req, dec_req, clr_req;
   logic [79:0] mem_rdata;
   logic [4:0]  mem_wr_stb;
   logic [15:0] mem_wdata;
   logic [7:0]  rd_sel;
   logic [31:0] rd_data;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   ctr_regfile uut (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .inc_req(inc_req),
      .dec_req(dec_req), .clr_req(clr_req), .mem_rdata(mem_rdata),
      .mem_wr_stb(mem_wr_stb), .mem_wdata(mem_wdata),
      .rd_sel(rd_sel), .rd_data(rd_data)
   );

   // {op[1:0], reg[3:0], data[15:0], expected[15:0]}; op 0 load, 1 inc, 2 dec, 3 both
   localparam logic [37:0] VEC [12] = '{
      {2'd0, 4'd1,  16'h1234, 16'h1234},
      {2'd1, 4'd1,  16'h0000, 16'h1235},
      {2'd2, 4'd1,  16'h0000, 16'h1234},
      {2'd3, 4'd1,  16'h0000, 16'h1234},
      {2'd0, 4'd10, 16'h0000, 16'h0000},
      {2'd2, 4'd10, 16'h0000, 16'hFFFF},
      {2'd1, 4'd10, 16'h0000, 16'h0000},
      {2'd0, 4'd5,  16'hFFFF, 16'hFFFF},
      {2'd1, 4'd5,  16'h0000, 16'h0000},
      {2'd0, 4'd14, 16'h00AB, 16'h00AB},
      {2'd0, 4'd2,  16'h5555, 16'h5555},
      {2'd1, 4'd6,  16'h0000, 16'h0001}
   };

   function automatic bit win(int n);
      return (n == 7) || (n >= 9 && (n % 2) == 1);
   endfunction

   function automatic logic [15:0] memval(int n);
      return 16'hD000 + 16'(((n - 7) / 2) * 16'h0111);
   endfunction

   task automatic idle();
      step_en = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
      inc_req = '0; dec_req = '0; clr_req = '0;
   endtask

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd2(string req, logic [3:0] na, logic [3:0] nb,
                      logic [15:0] ea, logic [15:0] eb);
      rd_sel = {nb, na};
      #1;
      check(req, rd_data[15:0], ea);
      check(req, rd_data[31:16], eb);
   endtask

   task automatic write(logic [3:0] n, logic [15:0] d);
      wr_en = 1'b1; wr_sel = n; wr_data = d;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
   end

   initial begin
      rst_n = 1'b0; idle(); rd_sel = '0;
      for (int k = 0; k < 5; k++) mem_rdata[k*16 +: 16] = memval(7 + 2*k);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int n = 0; n < 16; n++)
         if (!win(n)) rd2("R1", 4'(n), 4'(n), 16'h0000, 16'h0000);

      // R2 R3 R4: vector walk
      for (int v = 0; v < 12; v++) begin
         logic [1:0] op; logic [3:0] rn; logic [15:0] dv, ev;
         {op, rn, dv, ev} = VEC[v];
         @(negedge clk);
         case (op)
            2'd0: write(rn, dv);
            2'd1: inc_req[rn] = 1'b1;
            2'd2: dec_req[rn] = 1'b1;
            default: begin inc_req[rn] = 1'b1; dec_req[rn] = 1'b1; end
         endcase
         @(negedge clk); idle();
         rd2(op == 2'd0 ? "R2" : (op == 2'd3 ? "R4" : "R3"), rn, rn, ev, ev);
      end

      // R10: load every counter, read every number on both ports
      for (int n = 0; n < 16; n++) begin
         if (!win(n)) begin
            @(negedge clk); idle(); write(4'(n), 16'hA000 + 16'(n));
         end
      end
      @(negedge clk); idle();
      for (int n = 0; n < 16; n++) begin
         logic [15:0] ea, eb;
         ea = win(n) ? memval(n) : 16'hA000 + 16'(n);
         eb = win(15 - n) ? memval(15 - n) : 16'hA000 + 16'(15 - n);
         rd2(win(n) ? "R8" : "R10", 4'(n), 4'(15 - n), ea, eb);
      end

      // R9: write to a window, plus update/clear on windows
      @(negedge clk);
      write(4'd9, 16'hBEEF);
      inc_req[9] = 1'b1; clr_req[11] = 1'b1; dec_req[13] = 1'b1;
      #1;
      check("R9", 16'(mem_wr_stb), 16'h0002);
      check("R9", mem_wdata, 16'hBEEF);
      @(negedge clk); idle();
      rd2("R9", 4'd8, 4'd10, 16'hA008, 16'hA00A);
      rd2("R9", 4'd9, 4'd11, memval(9), memval(11));
      write(4'd12, 16'h0C0C);
      #1;
      check("R9", 16'(mem_wr_stb), 16'h0000);
      @(negedge clk); idle();
      rd2("R9", 4'd12, 4'd13, 16'h0C0C, memval(13));

      // R7: PC clear beats step, then steps ignoring update requests
      clr_req[0] = 1'b1; step_en = 1'b1;
      @(negedge clk); idle();
      rd2("R6", 4'd0, 4'd1, 16'h0000, 16'hA001);
      step_en = 1'b1; inc_req[0] = 1'b1;
      @(negedge clk); dec_req[0] = 1'b1; inc_req[0] = 1'b0;
      @(negedge clk); dec_req[0] = 1'b0;
      @(negedge clk); idle();
      rd2("R7", 4'd0, 4'd0, 16'h0003, 16'h0003);
      step_en = 1'b1; write(4'd0, 16'h0040);
      @(negedge clk); idle();
      rd2("R7", 4'd0, 4'd0, 16'h0040, 16'h0040);

      // R5: load beats update
      write(4'd3, 16'h0100); inc_req[3] = 1'b1;
      @(negedge clk); idle();
      write(4'd4, 16'h0200); dec_req[4] = 1'b1;
      @(negedge clk); idle();
      rd2("R5", 4'd3, 4'd4, 16'h0100, 16'h0200);

      // R6: clear beats load and update, neighbours untouched
      clr_req[2] = 1'b1; write(4'd2, 16'h7777); inc_req[2] = 1'b1;
      @(negedge clk); idle();
      rd2("R6", 4'd2, 4'd5, 16'h0000, 16'hA005);

      // R1: reset again
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd2("R1", 4'd1, 4'd6, 16'h0000, 16'h0000);
      rd2("R1", 4'd14, 4'd0, 16'h0000, 16'h0000);

      summary();
   end

endmodule